// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock Peripheral

This peripheral keeps a 32-bit count of elapsed seconds behind a small word-addressed register bus. It has select, write-enable, word address, write data and read data signals. The count steps by one on every single-cycle pulse of a one-per-second tick input and wraps from all ones back to zero. Software can preset the count, read back the preset value it last wrote, and set an alarm value. When the count steps onto the alarm value, a status flag is raised. A mask bit decides whether that flag reaches the interrupt pin.

The peripheral decodes a 4 KB window. Its registers sit at the bottom of the window, and eight identification words sit at the top. The control register always reports the counter as running, so the counter cannot be stopped. A block instantiates it on a peripheral bus and feeds it a tick that has already been synchronised to the bus clock.

Top module: `secs_rtc`

## Requirements
- R1: After reset, the count, alarm, preset, mask and raw flag all read zero, and `irq_o` is low.
- R2: A write to word offset 0x08 replaces the count with the written data in the next cycle. This applies even when a tick arrives in the same cycle.
- R3: On each cycle with `tick_i` high and no preset write, the count (read at offset 0x00) increases by one. 0xFFFFFFFF steps to 0x00000000. Without a tick, the count holds.
- R4: Offset 0x08 reads back the last value written to it, not the running count. Offset 0x04 (alarm) reads back the last value written to it.
- R5: Offset 0x10 stores only bit 0 of the written data. Bits 31:1 read as zero.
- R6: The raw flag (bit 0 of offset 0x14) becomes 1 in the cycle after a tick steps the count onto the alarm value. Presetting the count to the alarm value does not raise it.
- R7: A write of any data to offset 0x1C clears the raw flag. If a raise happens in the same cycle as the clear, the flag ends up set.
- R8: Offset 0x18 reads the raw flag ANDed with the mask bit, and `irq_o` carries the same value.
- R9: Offset 0x0C always reads 1. Writes to it change nothing, and the counter keeps counting after them.
- R10: Word offsets 0xFE0 to 0xFFC read 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0 in address order, with upper bits zero.
- R11: Offsets 0x020 to 0xFDC and offset 0x1C read zero. Writes there and to the identification words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| psel_i | input | 1 | Peripheral select |
| pwrite_i | input | 1 | 1 = write access, 0 = read access |
| paddr_i | input | 10 | Word address, byte offset bits 11:2 |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data; zero when not reading |
| irq_o | output | 1 | Masked alarm interrupt |

## Verification
Read data is combinational from the registers, so a read is sampled in the same cycle the address is driven. A write or a tick lands at the next rising edge. Its effect on the count, the flags and `irq_o` is therefore due one cycle later. The bench drives every access on a falling edge, samples reads shortly after that edge, and starts each read only after the edge that committed the preceding write or tick. The one-cycle latency of the raise, clear, set-versus-clear and preset-versus-tick cases is thus observed exactly at the first cycle it becomes visible.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned RTC_AW = 10;

  localparam logic [RTC_AW-1:0] OFS_COUNT = 10'h000;
  localparam logic [RTC_AW-1:0] OFS_ALARM = 10'h001;
  localparam logic [RTC_AW-1:0] OFS_PRESET = 10'h002;
  localparam logic [RTC_AW-1:0] OFS_CTRL = 10'h003;
  localparam logic [RTC_AW-1:0] OFS_MASK = 10'h004;
  localparam logic [RTC_AW-1:0] OFS_RAW = 10'h005;
  localparam logic [RTC_AW-1:0] OFS_MSK_ST = 10'h006;
  localparam logic [RTC_AW-1:0] OFS_CLEAR = 10'h007;
  localparam logic [RTC_AW-1:0] OFS_IDBASE = 10'h3F8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         preset_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] preset_o,
  output logic         adv_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] count_q, count_d;
  logic [W-1:0] preset_q, preset_d;
  logic         cnt_en;

  always_comb begin
    next_o   = count_q + W'(1);
    adv_o    = tick_i & ~preset_wr_i;
    cnt_en   = tick_i | preset_wr_i;
    count_d  = preset_wr_i ? wdata_i : next_o;
    preset_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      preset_q <= '0;
    end else begin
      if (cnt_en)      count_q  <= count_d;
      if (preset_wr_i) preset_q <= preset_d;
    end
  end

  assign count_o  = count_q;
  assign preset_o = preset_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alarm_wr_i,
  input  logic         mask_wr_i,
  input  logic         clear_i,
  input  logic [W-1:0] wdata_i,
  input  logic         adv_i,
  input  logic [W-1:0] next_cnt_i,
  output logic [W-1:0] alarm_o,
  output logic         mask_o,
  output logic         raw_o,
  output logic         irq_o
);
  logic [W-1:0] alarm_q;
  logic         mask_q, raw_q, raw_d, raw_en, hit;

  always_comb begin
    hit    = adv_i & (next_cnt_i == alarm_q);
    raw_en = hit | clear_i;
    raw_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (alarm_wr_i) alarm_q <= wdata_i;
      if (mask_wr_i)  mask_q  <= wdata_i[0];
      if (raw_en)     raw_q   <= raw_d;
    end
  end

  assign alarm_o = alarm_q;
  assign mask_o  = mask_q;
  assign raw_o   = raw_q;
  assign irq_o   = raw_q & mask_q;
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = RTC_AW
) (
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  count_i,
  input  logic [W-1:0]  alarm_i,
  input  logic [W-1:0]  preset_i,
  input  logic          mask_i,
  input  logic          raw_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned IDX_W = 3;

  logic          in_id;
  logic [AW-1:0] id_off;

  always_comb begin
    id_off  = addr_i - AW'(OFS_IDBASE);
    in_id   = (addr_i >= AW'(OFS_IDBASE));
    rdata_o = '0;
    if (rd_en_i) begin
      if (in_id) begin
        rdata_o = W'(id_byte(id_off[IDX_W-1:0]));
      end else begin
        case (addr_i)
          AW'(OFS_COUNT):  rdata_o = count_i;
          AW'(OFS_ALARM):  rdata_o = alarm_i;
          AW'(OFS_PRESET): rdata_o = preset_i;
          AW'(OFS_CTRL):   rdata_o = W'(1);
          AW'(OFS_MASK):   rdata_o = W'(mask_i);
          AW'(OFS_RAW):    rdata_o = W'(raw_i);
          AW'(OFS_MSK_ST): rdata_o = W'(raw_i & mask_i);
          default:         rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = RTC_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          psel_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [W-1:0]  pwdata_i,
  output logic [W-1:0]  prdata_o,
  output logic          irq_o
);
  logic         rst_meta_q, rst_sync_n;
  logic         wr_en, rd_en;
  logic         preset_wr, alarm_wr, mask_wr, clear_wr;
  logic [W-1:0] count_w, preset_w, alarm_w, next_w;
  logic         adv_w, mask_w, raw_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    wr_en     = psel_i & pwrite_i;
    rd_en     = psel_i & ~pwrite_i;
    preset_wr = wr_en & (paddr_i == AW'(OFS_PRESET));
    alarm_wr  = wr_en & (paddr_i == AW'(OFS_ALARM));
    mask_wr   = wr_en & (paddr_i == AW'(OFS_MASK));
    clear_wr  = wr_en & (paddr_i == AW'(OFS_CLEAR));
  end

  rtc_sec_counter #(.W(W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_i      (tick_i),
    .preset_wr_i (preset_wr),
    .wdata_i     (pwdata_i),
    .count_o     (count_w),
    .preset_o    (preset_w),
    .adv_o       (adv_w),
    .next_o      (next_w)
  );

  rtc_alarm_irq #(.W(W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .alarm_wr_i (alarm_wr),
    .mask_wr_i  (mask_wr),
    .clear_i    (clear_wr),
    .wdata_i    (pwdata_i),
    .adv_i      (adv_w),
    .next_cnt_i (next_w),
    .alarm_o    (alarm_w),
    .mask_o     (mask_w),
    .raw_o      (raw_w),
    .irq_o      (irq_o)
  );

  rtc_read_mux #(.W(W), .AW(AW)) u_rd (
    .rd_en_i  (rd_en),
    .addr_i   (paddr_i),
    .count_i  (count_w),
    .alarm_i  (alarm_w),
    .preset_i (preset_w),
    .mask_i   (mask_w),
    .raw_i    (raw_w),
    .rdata_o  (prdata_o)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = RTC_AW
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          tick_i,
  input logic          psel_i,
  input logic          pwrite_i,
  input logic [AW-1:0] paddr_i,
  input logic [W-1:0]  pwdata_i,
  input logic [W-1:0]  prdata_o,
  input logic          irq_o,
  input logic [W-1:0]  count_w,
  input logic [W-1:0]  alarm_w,
  input logic          mask_w,
  input logic          raw_w
);
  logic ld_wr, clr_wr, msk_wr, hit_c;
  assign ld_wr  = psel_i && pwrite_i && (paddr_i == AW'(OFS_PRESET));
  assign clr_wr = psel_i && pwrite_i && (paddr_i == AW'(OFS_CLEAR));
  assign msk_wr = psel_i && pwrite_i && (paddr_i == AW'(OFS_MASK));
  assign hit_c  = tick_i && !ld_wr && ((count_w + W'(1)) == alarm_w);

  a_r2_preset_loads: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_wr |=> (count_w == $past(pwdata_i)));
  a_r3_tick_steps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_i && !ld_wr) |=> (count_w == $past(count_w) + W'(1)));
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick_i && !ld_wr) |=> $stable(count_w));
  a_r5_mask_bit0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msk_wr |=> (mask_w == $past(pwdata_i[0])));
  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_c |=> raw_w);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_wr && !hit_c) |=> !raw_w);
  a_r8_masked_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (psel_i && !pwrite_i && paddr_i == AW'(OFS_MSK_ST)) |-> (prdata_o == W'(irq_o)));
  a_r9_ctrl_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (psel_i && !pwrite_i && paddr_i == AW'(OFS_CTRL)) |-> (prdata_o == W'(1)));
endmodule

bind secs_rtc rtc_checker #(.W(W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_i     (tick_i),
  .psel_i     (psel_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .pwdata_i   (pwdata_i),
  .prdata_o   (prdata_o),
  .irq_o      (irq_o),
  .count_w    (count_w),
  .alarm_w    (alarm_w),
  .mask_w     (mask_w),
  .raw_w      (raw_w)
);

// File: tb/tb_secs_rtc.sv
module tb_secs_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        psel_i = 1'b0;
  logic        pwrite_i = 1'b0;
  logic [9:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  secs_rtc dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .psel_i(psel_i),
    .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i),
    .prdata_o(prdata_o), .irq_o(irq_o)
  );

  // {word address, write data, expected read}: write then read back
  localparam int NV = 16;
  localparam logic [73:0] VEC [NV] = '{
    {10'h001, 32'h0000007B, 32'h0000007B},  // R4 alarm
    {10'h001, 32'hDEADBEEF, 32'hDEADBEEF},  // R4 alarm
    {10'h002, 32'h00001234, 32'h00001234},  // R4 preset
    {10'h004, 32'hFFFFFFFF, 32'h00000001},  // R5 mask
    {10'h004, 32'hFFFFFFFE, 32'h00000000},  // R5 mask
    {10'h003, 32'h00000000, 32'h00000001},  // R9 ctrl
    {10'h007, 32'h00000001, 32'h00000000},  // R11 clear reads 0
    {10'h008, 32'hFFFFFFFF, 32'h00000000},  // R11 reserved 0x020
    {10'h3F7, 32'hFFFFFFFF, 32'h00000000},  // R11 reserved 0xFDC
    {10'h3F8, 32'h00000000, 32'h00000031},  // R10
    {10'h3F9, 32'hFFFFFFFF, 32'h00000010},  // R10
    {10'h3FA, 32'h00000000, 32'h00000014},  // R10
    {10'h3FB, 32'h000000FF, 32'h00000000},  // R10
    {10'h3FC, 32'h00000000, 32'h0000000D},  // R10
    {10'h3FD, 32'h00000000, 32'h000000F0},  // R10
    {10'h3FF, 32'h00000000, 32'h000000B1}   // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    psel_i = 1; pwrite_i = 1; paddr_i = a; pwdata_i = d;
    @(negedge clk);
    psel_i = 0; pwrite_i = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    psel_i = 1; pwrite_i = 0; paddr_i = a;
    #1 d = prdata_o;
    psel_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(10'h000, v); chk("R1 count", v, 0);
    rd(10'h001, v); chk("R1 alarm", v, 0);
    rd(10'h002, v); chk("R1 preset", v, 0);
    rd(10'h004, v); chk("R1 mask", v, 0);
    rd(10'h005, v); chk("R1 raw", v, 0);
    #1 chk("R1 irq", irq_o, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      rd(VEC[i][73:64], v);
      chk($sformatf("table %0d", i), v, VEC[i][31:0]);
    end
    // R11 writes to id/reserved/clear did not disturb state
    rd(10'h000, v); chk("R11 count kept", v, 32'h1234);
    rd(10'h001, v); chk("R11 alarm kept", v, 32'hDEADBEEF);

    // R2, R3, R4
    wr(10'h002, 100);
    rd(10'h000, v); chk("R2 preset count", v, 100);
    ticks(3);
    rd(10'h000, v); chk("R3 ticks", v, 103);
    rd(10'h002, v); chk("R4 preset readback", v, 100);
    // R9 control write does not stop counting
    wr(10'h003, 0);
    ticks(1);
    rd(10'h000, v); chk("R9 still counting", v, 104);
    // R3 wrap
    wr(10'h002, 32'hFFFFFFFF);
    ticks(1);
    rd(10'h000, v); chk("R3 wrap", v, 0);
    // R2 preset wins over tick
    @(negedge clk);
    tick_i = 1; psel_i = 1; pwrite_i = 1; paddr_i = 10'h002; pwdata_i = 50;
    @(negedge clk);
    tick_i = 0; psel_i = 0; pwrite_i = 0;
    rd(10'h000, v); chk("R2 preset beats tick", v, 50);

    // R6, R8, R7 alarm path
    wr(10'h004, 0);
    wr(10'h002, 10);
    wr(10'h001, 12);
    ticks(1);
    rd(10'h005, v); chk("R6 no raise before match", v, 0);
    ticks(1);
    rd(10'h005, v); chk("R6 raise on match", v, 1);
    rd(10'h006, v); chk("R8 masked status off", v, 0);
    #1 chk("R8 irq masked", irq_o, 0);
    wr(10'h004, 1);
    rd(10'h006, v); chk("R8 masked status on", v, 1);
    #1 chk("R8 irq on", irq_o, 1);
    wr(10'h007, 32'hA5A5A5A5);
    rd(10'h005, v); chk("R7 clear", v, 0);
    #1 chk("R8 irq after clear", irq_o, 0);
    // R7 raise beats clear
    wr(10'h002, 20);
    wr(10'h001, 21);
    @(negedge clk);
    tick_i = 1; psel_i = 1; pwrite_i = 1; paddr_i = 10'h007; pwdata_i = 0;
    @(negedge clk);
    tick_i = 0; psel_i = 0; pwrite_i = 0;
    rd(10'h005, v); chk("R7 raise beats clear", v, 1);
    // R6 preset onto alarm does not raise
    wr(10'h007, 0);
    wr(10'h001, 30);
    wr(10'h002, 30);
    rd(10'h005, v); chk("R6 preset no raise", v, 0);

    finish_run();
  end
endmodule